// File: doc/BRIEF.md
# Self-Routing Butterfly Switch Network

This block moves fixed-format packets from N injection lines to N delivery lines through log2 N stages. Each stage has N/2 two-by-two switch elements. A packet enters on the line equal to its source address and names its destination address. The source line is stamped into the packet when it enters. No switch holds a routing table. Stage i pairs the two lines whose indices differ only in bit i. The switch sends the packet straight when bit i of the relative address (source xor destination) is 0, and across when that bit is 1. A crossing flips bit i of the line the packet is on. After the last stage the line index equals the destination, so each source and destination pair has exactly one path.

Every stage ends in one register. A packet that meets no contention therefore appears at its delivery line log2 N cycles after it is accepted. Two packets in one switch may ask for the same output in the same cycle. A per-switch round-robin pointer then picks the winner. The loser waits in a one-entry holding slot at its switch input, and that slot being full stops the line feeding it. At the injection side, a packet is taken in a cycle where both `in_valid` and `in_ready` are high. Delivery lines never stall.

Each switch input runs a two-state machine. `SLOT_EMPTY` moves to `SLOT_HELD` (capture) when a valid incoming packet cannot move forward. `SLOT_HELD` returns to `SLOT_EMPTY` (release) when the held packet is granted. Each switch also runs a priority machine. In `PRI_LO` the lower-indexed line wins a clash, and in `PRI_HI` the upper line wins. The machine toggles between the two (flip) on every clash that is granted. Both machines reset to `SLOT_EMPTY` and `PRI_LO`.

Top module: `bfly_network`

## Requirements
- R1: While reset is asserted and right after it, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A packet accepted on line A with destination B and no contention appears on delivery line B exactly log2 N cycles later. It carries its payload unchanged and `out_dst` equal to B.
- R3: The delivered packet's `out_src` equals the injection line A. At stage i the packet leaves on the line whose bit i equals bit i of its destination.
- R4: When all N lines inject at once with destinations B = A xor C for any constant C, all N packets arrive in the same cycle, log2 N cycles later, with no stall.
- R5: When both inputs of a switch request the same output, the priority state picks the winner. After reset it favours the lower line, and it toggles after each granted clash, so the next clash in that switch goes to the other line.
- R6: The losing packet is kept in its input's holding slot. `in_ready` of that line reads 0 from the cycle after the clash until the packet is released. The held packet goes forward in a later cycle, so it is delivered one cycle after the winner when nothing else is in the way.
- R7: No packet is lost or duplicated. With all N lines injecting to one destination at once, exactly N packets reach that line, one from each source, and none reaches any other line.
- R8: Each delivered packet raises its `out_valid` bit for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Injection request, one bit per line |
| in_dst | input | N*AW | Destination address per line, line j at bits j*AW +: AW |
| in_data | input | N*DW | Payload per line, line j at bits j*DW +: DW |
| in_ready | output | N | Line may inject this cycle |
| out_valid | output | N | Packet delivered on this line |
| out_dst | output | N*AW | Destination field of the delivered packet |
| out_src | output | N*AW | Source line of the delivered packet |
| out_data | output | N*DW | Payload of the delivered packet |

## Verification
Clash arbitration and the blocked-output stall can fall in the same switch in the same cycle. In that case a held loser is waiting, and its output register is itself stalled because the next stage's slot is full. A burst in which every line aims at one destination causes this, since clashes then pile up across all three stages at once. It is judged at the delivery line by counting exactly N arrivals, one per source, with matching payloads and nothing on any other line. A two-packet clash is also replayed after reset to show that the winner alternates between rounds and that `in_ready` of the losing line drops for exactly the held cycle.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_e;

    typedef enum logic {
        PRI_LO = 1'b0,
        PRI_HI = 1'b1
    } pri_e;

endpackage

// File: rtl/bfly_switch.sv
module bfly_switch
    import bfly_pkg::*;
#(
    parameter int AW    = 3,
    parameter int PW    = 22,
    parameter int STAGE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          in_v,
    input  logic [1:0][PW-1:0]  in_p,
    output logic [1:0]          in_rdy,
    output logic [1:0]          out_v,
    output logic [1:0][PW-1:0]  out_p,
    input  logic [1:0]          dn_rdy
);
    localparam int DW = PW - 2 * AW;

    typedef struct packed {
        logic [AW-1:0] dst;
        logic [AW-1:0] src;
        logic [DW-1:0] data;
    } pkt_t;

    slot_e        slot_q [2];
    slot_e        slot_d [2];
    pkt_t         hold_q [2];
    pri_e         pri_q, pri_d;
    logic [1:0]   ov_q, ov_d;
    pkt_t [1:0]   op_q, op_d;

    logic [1:0]   cand_v, want, free, go, take;
    pkt_t [1:0]   cand;
    logic         clash, cgrant;

    always_comb begin
        for (int k = 0; k < 2; k++) begin
            cand_v[k] = (slot_q[k] == SLOT_HELD) ? 1'b1 : in_v[k];
            cand[k]   = (slot_q[k] == SLOT_HELD) ? hold_q[k] : pkt_t'(in_p[k]);
            want[k]   = cand[k].dst[STAGE];
            take[k]   = in_v[k] && (slot_q[k] == SLOT_EMPTY);
        end
        for (int o = 0; o < 2; o++) begin
            free[o] = !ov_q[o] || dn_rdy[o];
        end
        clash  = cand_v[0] && cand_v[1] && (want[0] == want[1]);
        cgrant = clash && free[want[0]];
        go[0]  = cand_v[0] && free[want[0]] && (!clash || pri_q == PRI_LO);
        go[1]  = cand_v[1] && free[want[1]] && (!clash || pri_q == PRI_HI);
    end

    // Holding-slot and priority state machines: next-state logic
    always_comb begin
        for (int k = 0; k < 2; k++) begin
            slot_d[k] = slot_q[k];
            unique case (slot_q[k])
                SLOT_EMPTY: if (in_v[k] && !go[k]) slot_d[k] = SLOT_HELD;  // capture
                SLOT_HELD:  if (go[k])             slot_d[k] = SLOT_EMPTY; // release
                default:                           slot_d[k] = SLOT_EMPTY;
            endcase
        end
        pri_d = pri_q;
        unique case (pri_q)
            PRI_LO:  if (cgrant) pri_d = PRI_HI;  // flip
            PRI_HI:  if (cgrant) pri_d = PRI_LO;  // flip
            default: pri_d = PRI_LO;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q[0] <= SLOT_EMPTY;
            slot_q[1] <= SLOT_EMPTY;
            pri_q     <= PRI_LO;
        end else begin
            slot_q[0] <= slot_d[0];
            slot_q[1] <= slot_d[1];
            pri_q     <= pri_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (slot_q[k] == SLOT_EMPTY && in_v[k] && !go[k]) begin
                hold_q[k] <= cand[k];
            end
        end
    end

    // Output register: next value
    always_comb begin
        for (int o = 0; o < 2; o++) begin
            ov_d[o] = ov_q[o];
            op_d[o] = op_q[o];
            if (go[0] && want[0] == 1'(o)) begin
                ov_d[o] = 1'b1;
                op_d[o] = cand[0];
            end else if (go[1] && want[1] == 1'(o)) begin
                ov_d[o] = 1'b1;
                op_d[o] = cand[1];
            end else if (dn_rdy[o]) begin
                ov_d[o] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= '0;
        end else begin
            ov_q <= ov_d;
        end
        op_q <= op_d;
    end

    always_comb begin
        for (int k = 0; k < 2; k++) begin
            in_rdy[k] = (slot_q[k] == SLOT_EMPTY);
            out_v[k]  = ov_q[k];
            out_p[k]  = op_q[k];
        end
    end

    // Occupancy bookkeeping for the conservation check
    int cnt_now, acc_now, drn_now;
    always_comb begin
        cnt_now = 0;
        acc_now = 0;
        drn_now = 0;
        for (int k = 0; k < 2; k++) begin
            cnt_now += int'(ov_q[k]) + int'(slot_q[k] == SLOT_HELD);
            acc_now += int'(take[k]);
            drn_now += int'(ov_q[k] && dn_rdy[k]);
        end
    end

    p_conserve_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_now == $past(cnt_now + acc_now - drn_now))
        else $error("switch lost or duplicated a packet");

    p_rr_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cgrant |=> pri_q != $past(pri_q))
        else $error("priority did not toggle after clash");

    p_loser_hi_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cgrant && pri_q == PRI_LO) |=> slot_q[1] == SLOT_HELD)
        else $error("upper loser not held");

    p_loser_lo_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cgrant && pri_q == PRI_HI) |=> slot_q[0] == SLOT_HELD)
        else $error("lower loser not held");

    p_route_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ov_q[0] |-> op_q[0].dst[STAGE] == 1'b0)
        else $error("packet on wrong lower output");

    p_route_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ov_q[1] |-> op_q[1].dst[STAGE] == 1'b1)
        else $error("packet on wrong upper output");

endmodule

// File: rtl/bfly_stage.sv
module bfly_stage #(
    parameter int N     = 8,
    parameter int AW    = 3,
    parameter int PW    = 22,
    parameter int STAGE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         in_v,
    input  logic [N-1:0][PW-1:0] in_p,
    output logic [N-1:0]         in_rdy,
    output logic [N-1:0]         out_v,
    output logic [N-1:0][PW-1:0] out_p,
    input  logic [N-1:0]         dn_rdy
);
    localparam int NSW  = N / 2;
    localparam int STEP = 1 << STAGE;

    for (genvar s = 0; s < NSW; s++) begin : g_sw
        localparam int LO = ((s >> STAGE) << (STAGE + 1)) | (s & (STEP - 1));
        localparam int HI = LO + STEP;

        logic [1:0]          sw_rdy, sw_ov;
        logic [1:0][PW-1:0]  sw_op;

        bfly_switch #(
            .AW    (AW),
            .PW    (PW),
            .STAGE (STAGE)
        ) u_sw (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_v   ({in_v[HI], in_v[LO]}),
            .in_p   ({in_p[HI], in_p[LO]}),
            .in_rdy (sw_rdy),
            .out_v  (sw_ov),
            .out_p  (sw_op),
            .dn_rdy ({dn_rdy[HI], dn_rdy[LO]})
        );

        assign in_rdy[LO] = sw_rdy[0];
        assign in_rdy[HI] = sw_rdy[1];
        assign out_v[LO]  = sw_ov[0];
        assign out_v[HI]  = sw_ov[1];
        assign out_p[LO]  = sw_op[0];
        assign out_p[HI]  = sw_op[1];
    end

endmodule

// File: rtl/bfly_network.sv
module bfly_network #(
    parameter int N  = 8,
    parameter int DW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            in_valid,
    input  logic [N*$clog2(N)-1:0]  in_dst,
    input  logic [N*DW-1:0]         in_data,
    output logic [N-1:0]            in_ready,
    output logic [N-1:0]            out_valid,
    output logic [N*$clog2(N)-1:0]  out_dst,
    output logic [N*$clog2(N)-1:0]  out_src,
    output logic [N*DW-1:0]         out_data
);
    localparam int AW = $clog2(N);
    localparam int S  = AW;
    localparam int PW = 2 * AW + DW;

    logic [N-1:0]         lv_v   [S+1];
    logic [N-1:0]         lv_rdy [S+1];
    logic [N-1:0][PW-1:0] lv_p   [S+1];

    assign lv_v[0]   = in_valid;
    assign in_ready  = lv_rdy[0];
    assign lv_rdy[S] = '1;

    for (genvar j = 0; j < N; j++) begin : g_line
        assign lv_p[0][j] = {in_dst[j*AW +: AW], AW'(j), in_data[j*DW +: DW]};
        assign out_dst[j*AW +: AW]  = lv_p[S][j][PW-1 -: AW];
        assign out_src[j*AW +: AW]  = lv_p[S][j][DW +: AW];
        assign out_data[j*DW +: DW] = lv_p[S][j][DW-1:0];

        p_out_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> out_dst[j*AW +: AW] == AW'(j))
            else $error("packet delivered on wrong line");
    end

    assign out_valid = lv_v[S];

    for (genvar s = 0; s < S; s++) begin : g_stage
        bfly_stage #(
            .N     (N),
            .AW    (AW),
            .PW    (PW),
            .STAGE (s)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_v   (lv_v[s]),
            .in_p   (lv_p[s]),
            .in_rdy (lv_rdy[s]),
            .out_v  (lv_v[s+1]),
            .out_p  (lv_p[s+1]),
            .dn_rdy (lv_rdy[s+1])
        );
    end

endmodule

// File: tb/tb_bfly_network.sv
module tb_bfly_network;
    localparam int N  = 8;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam int S  = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N-1:0]      in_valid;
    logic [N*AW-1:0]   in_dst;
    logic [N*DW-1:0]   in_data;
    logic [N-1:0]      in_ready;
    logic [N-1:0]      out_valid;
    logic [N*AW-1:0]   out_dst;
    logic [N*AW-1:0]   out_src;
    logic [N*DW-1:0]   out_data;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    bfly_network #(.N(N), .DW(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dst    (in_dst),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_dst   (out_dst),
        .out_src   (out_src),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int src_of(input int line);
        return int'(out_src[line*AW +: AW]);
    endfunction

    function automatic int data_of(input int line);
        return int'(out_data[line*DW +: DW]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = '0;
        in_dst   = '0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_ready == '1, "R1 in_ready in reset", int'(in_ready), 255);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == '1, "R1 in_ready after reset", int'(in_ready), 255);
    endtask

    task automatic t_single(input int src, input int dst);
        int pay;
        pay = 16'h5000 + src * 16 + dst;
        @(negedge clk);
        in_valid[src] = 1'b1;
        in_dst[src*AW +: AW]  = AW'(dst);
        in_data[src*DW +: DW] = DW'(pay);
        @(negedge clk);
        in_valid = '0;
        repeat (S - 1) @(negedge clk);
        chk(out_valid == N'(1 << dst), "R2 arrival line/latency", int'(out_valid), 1 << dst);
        chk(src_of(dst) == src, "R3 source line", src_of(dst), src);
        chk(data_of(dst) == pay, "R2 payload", data_of(dst), pay);
        @(negedge clk);
        chk(out_valid == '0, "R8 single-cycle pulse", int'(out_valid), 0);
    endtask

    task automatic t_xor_perm(input int c);
        @(negedge clk);
        for (int j = 0; j < N; j++) begin
            in_dst[j*AW +: AW]  = AW'(j ^ c);
            in_data[j*DW +: DW] = DW'(16'h7000 + j * 16 + c);
        end
        in_valid = '1;
        @(negedge clk);
        in_valid = '0;
        repeat (S - 1) @(negedge clk);
        chk(out_valid == '1, "R4 all arrive together", int'(out_valid), 255);
        for (int j = 0; j < N; j++) begin
            chk(src_of(j) == (j ^ c), "R4 xor permutation source", src_of(j), j ^ c);
            chk(data_of(j) == 16'h7000 + (j ^ c) * 16 + c, "R4 payload",
                data_of(j), 16'h7000 + (j ^ c) * 16 + c);
        end
        @(negedge clk);
        chk(out_valid == '0, "R8 pulse after permutation", int'(out_valid), 0);
    endtask

    task automatic clash_round(input int first, input int second);
        @(negedge clk);
        for (int j = 0; j < 2; j++) begin
            in_dst[j*AW +: AW]  = '0;
            in_data[j*DW +: DW] = DW'(16'h9000 + j);
        end
        in_valid[1:0] = 2'b11;
        @(negedge clk);
        in_valid = '0;
        chk(in_ready[second] == 1'b0, "R6 loser line not ready", int'(in_ready[second]), 0);
        chk(in_ready[first] == 1'b1, "R6 winner line ready", int'(in_ready[first]), 1);
        repeat (S - 1) @(negedge clk);
        chk(out_valid == 8'h01, "R5 winner arrives", int'(out_valid), 1);
        chk(src_of(0) == first, "R5 round-robin winner", src_of(0), first);
        @(negedge clk);
        chk(out_valid == 8'h01, "R6 held packet arrives next", int'(out_valid), 1);
        chk(src_of(0) == second, "R6 held packet source", src_of(0), second);
        chk(data_of(0) == 16'h9000 + second, "R6 held payload", data_of(0), 16'h9000 + second);
        chk(in_ready == '1, "R6 ready restored", int'(in_ready), 255);
        @(negedge clk);
        chk(out_valid == '0, "R8 no repeat after clash", int'(out_valid), 0);
    endtask

    task automatic t_clash();
        do_reset();
        clash_round(0, 1);
        clash_round(1, 0);
    endtask

    task automatic t_burst(input int dst);
        int seen_mask;
        int count;
        int stray;
        int bad_pay;
        seen_mask = 0;
        count     = 0;
        stray     = 0;
        bad_pay   = 0;
        do_reset();
        @(negedge clk);
        for (int j = 0; j < N; j++) begin
            in_dst[j*AW +: AW]  = AW'(dst);
            in_data[j*DW +: DW] = DW'(16'hb000 + j);
        end
        in_valid = '1;
        @(negedge clk);
        in_valid = '0;
        for (int t = 0; t < 40; t++) begin
            if ((out_valid & ~N'(1 << dst)) != '0) stray++;
            if (out_valid[dst]) begin
                if ((seen_mask & (1 << src_of(dst))) != 0) count += 100;
                seen_mask |= 1 << src_of(dst);
                count++;
                if (data_of(dst) != 16'hb000 + src_of(dst)) bad_pay++;
            end
            @(negedge clk);
        end
        chk(count == N, "R7 delivered count", count, N);
        chk(seen_mask == 255, "R7 every source once", seen_mask, 255);
        chk(stray == 0, "R7 nothing on other lines", stray, 0);
        chk(bad_pay == 0, "R7 payloads intact", bad_pay, 0);
        chk(in_ready == '1, "R6 all slots released", int'(in_ready), 255);
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = '0;
        in_dst   = '0;
        in_data  = '0;
        do_reset();
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                t_single(a, b);
            end
        end
        for (int c = 0; c < N; c++) begin
            t_xor_perm(c);
        end
        t_clash();
        t_burst(2);
        t_burst(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule